// File: doc/BRIEF.md
# Instruction Predecode and Parity Formatter

This block sits on the instruction-cache fill path. Each 32-bit instruction word it accepts becomes a 34-bit cache entry. The entry carries the word itself, a predecode flag and a parity bit. The flag marks instructions that the fetch logic must treat specially: control transfers, multi-cycle arithmetic, most loads and stores, and privileged or state-register accesses. Later stages can then recognise these instructions without decoding them again. The parity bit protects both the word and the flag.

Words enter through a valid/ready handshake. A single output register holds each formatted entry, so an accepted word appears on the output one cycle later. When the consumer stalls, the output register keeps its value. The input side can accept a new word in the same cycle that the output register drains, so one word per cycle passes at full rate.

Top module: `ipf_formatter`

## Requirements
- R1: The entry layout is: bit 0 = predecode flag, bits 32:1 = the accepted word unchanged, bit 33 = parity.
- R2: Bit 33 equals the XOR of entry bits 32:0, so the XOR of all 34 entry bits is 0.
- R3: When word bits 31:30 = 1, the flag is 1.
- R4: When word bits 31:30 = 0, the flag is 0 if bits 24:22 = 4, and 1 for any other value.
- R5: When word bits 31:30 = 2 and bits 24:23 = 3, the flag is 1.
- R6: When word bits 31:30 = 2 and bit 24 = 0, the flag is 0 if bit 22 = 0. It is also 0 if bit 22 = 1 and bits 20:19 = 0. Otherwise it is 1.
- R7: When word bits 31:30 = 2 and bits 24:23 = 2, take the field F = bits 22:19. F = 4 gives 1. Otherwise F with its top bit clear gives 0. Otherwise F = 0xC or F = 0xF gives 0. Any other F gives 1.
- R8: When word bits 31:30 = 3, the flag is 1 if bit 24 = 1, bit 23 = 1 or bit 21 = 0. Otherwise it is 0 if bits 22:19 = 0xE or if bit 22 = 0. Otherwise it is 1.
- R9: A word accepted at a clock edge (in_valid and in_ready both high) appears with out_valid high after that same edge.
- R10: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged at the next edge.
- R11: in_ready is high exactly when out_valid is low or out_ready is high.
- R12: A synchronous active-high reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction word is offered |
| in_ready | output | 1 | The block can take a word this cycle |
| in_data | input | 32 | Instruction word |
| out_valid | output | 1 | A formatted entry is held |
| out_ready | input | 1 | The consumer takes the entry this cycle |
| out_data | output | 34 | Formatted entry {parity, word, flag} |

## Verification
Draining the held entry and loading a new word can happen at the same edge. This occurs when out_valid, out_ready and in_valid are all high. The bench provokes it by sending words back to back while out_ready is held high and, in another phase, toggled on a pseudo-random pattern. A scoreboard checks that no entry is lost or duplicated and that every entry arrives in order with the expected flag and parity. Separate checks in stalled cycles confirm that the held entry stays stable and that in_ready drops.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
   localparam int unsigned INSN_W  = 32;
   localparam int unsigned ENTRY_W = INSN_W + 2;
   localparam int unsigned DEC_LO  = 19;
   localparam int unsigned DEC_W   = INSN_W - DEC_LO;

   typedef enum logic [1:0] {
      CLS_BRANCH = 2'd0,
      CLS_CALL   = 2'd1,
      CLS_ALU    = 2'd2,
      CLS_MEM    = 2'd3
   } insn_cls_e;

   typedef struct packed {
      logic              par;
      logic [INSN_W-1:0] word;
      logic              flag;
   } entry_t;
endpackage

// File: rtl/ipf_predecode.sv
module ipf_predecode
   import ipf_pkg::*;
(
   input  logic [DEC_W-1:0] op_bits,
   output logic             flag
);
   // op_bits[k] is word bit (k + DEC_LO)
   localparam int unsigned B31 = 31 - DEC_LO;
   localparam int unsigned B30 = 30 - DEC_LO;
   localparam int unsigned B24 = 24 - DEC_LO;
   localparam int unsigned B23 = 23 - DEC_LO;
   localparam int unsigned B22 = 22 - DEC_LO;
   localparam int unsigned B21 = 21 - DEC_LO;
   localparam int unsigned B20 = 20 - DEC_LO;
   localparam int unsigned B19 = 19 - DEC_LO;

   insn_cls_e  cls;
   logic       f_branch, f_alu, f_mem;
   logic [3:0] sub_f;

   assign cls   = insn_cls_e'(op_bits[B31:B30]);
   assign sub_f = op_bits[B22:B19];

   always_comb begin
      f_branch = (op_bits[B24:B22] != 3'd4);
   end

   always_comb begin
      if (op_bits[B24:B23] == 2'b11) begin
         f_alu = 1'b1;
      end else if (!op_bits[B24]) begin
         if (!op_bits[B22])                      f_alu = 1'b0;
         else if (op_bits[B20:B19] == 2'b00)     f_alu = 1'b0;
         else                                    f_alu = 1'b1;
      end else begin
         if (sub_f == 4'h4)                      f_alu = 1'b1;
         else if (!sub_f[3])                     f_alu = 1'b0;
         else if (sub_f == 4'hC || sub_f == 4'hF) f_alu = 1'b0;
         else                                    f_alu = 1'b1;
      end
   end

   always_comb begin
      if (op_bits[B24] || op_bits[B23] || !op_bits[B21]) f_mem = 1'b1;
      else if (sub_f == 4'hE)                            f_mem = 1'b0;
      else if (op_bits[B22:B21] == 2'b01)                f_mem = 1'b0;
      else                                               f_mem = 1'b1;
   end

   always_comb begin
      unique case (cls)
         CLS_CALL:   flag = 1'b1;
         CLS_BRANCH: flag = f_branch;
         CLS_ALU:    flag = f_alu;
         default:    flag = f_mem;
      endcase
   end
endmodule

// File: rtl/ipf_parity.sv
module ipf_parity #(
   parameter int unsigned VEC_W   = 33,
   parameter int unsigned GROUP_W = 4,
   parameter bit          GROUPED = 1'b1
) (
   input  logic [VEC_W-1:0] vec,
   output logic             par
);
   localparam int unsigned N_GRP = (VEC_W + GROUP_W - 1) / GROUP_W;
   localparam int unsigned PAD_W = N_GRP * GROUP_W;

   if (GROUP_W < 1) begin : g_bad_grp
      $error("ipf_parity: GROUP_W must be at least 1");
   end

   if (GROUPED) begin : g_grouped
      logic [PAD_W-1:0] padded;
      logic [N_GRP-1:0] grp_par;
      assign padded = PAD_W'(vec);
      for (genvar g = 0; g < N_GRP; g++) begin : g_grp
         assign grp_par[g] = ^padded[g*GROUP_W +: GROUP_W];
      end
      assign par = ^grp_par;
   end else begin : g_flat
      assign par = ^vec;
   end
endmodule

// File: rtl/ipf_out_stage.sv
module ipf_out_stage #(
   parameter int unsigned DATA_W = 34
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_valid,
   output logic              load_ready,
   input  logic [DATA_W-1:0] load_data,
   output logic              held_valid,
   input  logic              take,
   output logic [DATA_W-1:0] held_data
);
   logic accept;

   assign load_ready = !held_valid || take;
   assign accept     = load_valid && load_ready;

   always_ff @(posedge clk) begin
      if (rst)                 held_valid <= 1'b0;
      else if (accept)         held_valid <= 1'b1;
      else if (take)           held_valid <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (accept) held_data <= load_data;
   end

   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      held_valid && !take |=> held_valid && $stable(held_data));

   p_accept_r9: assert property (@(posedge clk) disable iff (rst)
      load_valid && load_ready |=> held_valid && held_data == $past(load_data));

   p_drain_r11: assert property (@(posedge clk) disable iff (rst)
      held_valid && take && !load_valid |=> !held_valid);
endmodule

// File: rtl/ipf_formatter.sv
module ipf_formatter
   import ipf_pkg::*;
#(
   parameter int unsigned WORD_W      = 32,
   parameter int unsigned PAR_GROUP_W = 4,
   parameter bit          PAR_GROUPED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W+1:0] out_data
);
   localparam int unsigned OUT_W = WORD_W + 2;

   if (WORD_W != INSN_W) begin : g_bad_width
      $error("ipf_formatter: WORD_W must equal the decoded word width");
   end

   logic   pd_flag;
   logic   par_bit;
   entry_t nxt;

   ipf_predecode u_dec (
      .op_bits (in_data[INSN_W-1:DEC_LO]),
      .flag    (pd_flag)
   );

   ipf_parity #(
      .VEC_W   (WORD_W + 1),
      .GROUP_W (PAR_GROUP_W),
      .GROUPED (PAR_GROUPED)
   ) u_par (
      .vec (nxt[WORD_W:0]),
      .par (par_bit)
   );

   always_comb begin
      nxt.flag = pd_flag;
      nxt.word = in_data;
      nxt.par  = par_bit;
   end

   ipf_out_stage #(.DATA_W(OUT_W)) u_out (
      .clk        (clk),
      .rst        (rst),
      .load_valid (in_valid),
      .load_ready (in_ready),
      .load_data  (nxt),
      .held_valid (out_valid),
      .take       (out_ready),
      .held_data  (out_data)
   );

   p_even_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (^out_data) == 1'b0);

   p_word_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_data[WORD_W:1] == $past(in_data));

   p_call_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready && in_data[31:30] == 2'b01 |=> out_data[0]);
endmodule

// File: tb/ipf_formatter_tb_top.sv
module ipf_formatter_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [33:0] out_data;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int ready_mode = 0;
   logic [15:0] rdy_lfsr = 16'hACE1;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        stalled = 1'b0;
   logic [33:0] stall_data = '0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   ipf_formatter dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

   function automatic logic ref_flag(input logic [31:0] w);
      logic [3:0] f;
      f = w[22:19];
      case (w[31:30])
         2'd1: return 1'b1;
         2'd0: return w[24:22] != 3'd4;
         2'd2: begin
            if (w[24:23] == 2'd3) return 1'b1;
            if (w[24] == 1'b0) return w[22] && (w[20:19] != 2'd0);
            if (f == 4'h4) return 1'b1;
            if (f < 4'h8) return 1'b0;
            return !(f == 4'hC || f == 4'hF);
         end
         default: begin
            if (w[24] || w[23] || !w[21]) return 1'b1;
            if (f == 4'hE || !w[22]) return 1'b0;
            return 1'b1;
         end
      endcase
   endfunction

   function automatic logic [33:0] ref_entry(input logic [31:0] w);
      logic fl;
      fl = ref_flag(w);
      return {^{w, fl}, w, fl};
   endfunction

   task automatic check(input bit ok, input string req, input logic [33:0] act,
                        input logic [33:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: offers a word at negedge, pushes expectation on handshake
   task automatic send(input logic [31:0] w, input string req);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      forever begin
         #5;
         if (in_ready) begin
            exp_q.push_back(w);
            tag_q.push_back(req);
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // ready pattern generator
   always @(negedge clk) begin
      rdy_lfsr <= {rdy_lfsr[14:0], rdy_lfsr[15] ^ rdy_lfsr[13] ^ rdy_lfsr[12] ^ rdy_lfsr[10]};
      case (ready_mode)
         0: out_ready <= 1'b1;
         1: out_ready <= rdy_lfsr[0];
         2: out_ready <= 1'b0;
         default: out_ready <= ~out_ready;
      endcase
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      #6;
      if (!rst) begin
         check(in_ready == (!out_valid || out_ready), "R11",
               {33'd0, in_ready}, {33'd0, (!out_valid || out_ready)});
         if (stalled)
            check(out_valid && out_data == stall_data, "R10", out_data, stall_data);
         stalled    = out_valid && !out_ready;
         stall_data = out_data;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 unexpected entry", out_data, '0);
            end else begin
               logic [33:0] e;
               string t;
               e = ref_entry(exp_q.pop_front());
               t = tag_q.pop_front();
               check(out_data == e, t, out_data, e);
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] lw;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #5;
      check(out_valid == 1'b0, "R12 reset", {33'd0, out_valid}, '0);
      @(negedge clk);
      rst = 1'b0;
      #5;
      check(out_valid == 1'b0 && in_ready == 1'b1, "R12 after reset",
            {32'd0, out_valid, in_ready}, 34'd1);

      // R9: one-cycle latency
      ready_mode = 2;
      send(32'h4000_0000, "R3");
      #3;
      check(out_valid == 1'b1 && out_data[32:1] == 32'h4000_0000, "R9",
            out_data, ref_entry(32'h4000_0000));
      idle();
      repeat (3) @(negedge clk);
      ready_mode = 0;
      repeat (2) @(negedge clk);

      // directed decode vectors, full rate
      send(32'h4123_4567, "R3");
      send(32'h0100_0000, "R4");
      send(32'h0080_0000, "R4");
      send(32'h3F00_0000, "R4");
      send(32'h8180_0000, "R5");
      send(32'h8000_0000, "R6");
      send(32'h8040_0000, "R6");
      send(32'h8048_0000, "R6");
      send(32'h8058_0000, "R6");
      send(32'h8120_0000, "R7");
      send(32'h8100_0000, "R7");
      send(32'h8160_0000, "R7");
      send(32'h8178_0000, "R7");
      send(32'h8148_0000, "R7");
      send(32'h8150_0000, "R7");
      send(32'hC100_0000, "R8");
      send(32'hC080_0000, "R8");
      send(32'hC000_0000, "R8");
      send(32'hC020_0000, "R8");
      send(32'hC070_0000, "R8");
      send(32'hC078_0000, "R8");
      send(32'hC060_0000, "R8");
      send(32'hFFFF_FFFF, "R1");
      send(32'h0000_0001, "R2");
      idle();

      // pseudo-random words under random back-pressure
      ready_mode = 1;
      lw = 32'h1357_9BDF;
      for (int i = 0; i < 300; i++) begin
         lw = {lw[30:0], lw[31] ^ lw[21] ^ lw[1] ^ lw[0]};
         send(lw, "R1 R2");
      end
      idle();

      // alternating back-pressure
      ready_mode = 3;
      for (int i = 0; i < 40; i++) begin
         lw = lw * 32'd1664525 + 32'd1013904223;
         send(lw, "R10 R1");
      end
      idle();
      ready_mode = 0;
      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R9 drained", 34'(exp_q.size()), '0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule